// File: doc/BRIEF.md
# Masked Zero-Run Counter

This block takes two 128-bit operands, a data word and a selection mask, and treats each as two independent 64-bit lanes. In every lane it keeps only the data bits whose mask bit is set, then counts the unbroken run of zeros at one end of that reduced bit string. A single direction input chooses the end. When it is low, the count runs from the most significant selected bit downward. When it is high, the count runs from the least significant selected bit upward.

The counting logic is purely combinational. One register stage with a clock enable sits behind it, and a valid flag travels alongside the data. Each lane's count appears zero-extended in its own 64-bit result lane one clock after the operands are presented. Positions whose mask bit is clear are passed over entirely, so they can neither end a run nor add to it.

Top module: `mzc_top`

## Requirements
- R1: With `count_from_lsb` = 0, a lane's count is the number of mask-selected data bits that are 0, taken from the most significant selected position downward and stopping at the first selected data bit that is 1. Data 0x0123456789abcdef gives 5 with mask 0xaaaaaaaaaaaaaaaa and 9 with mask 0xcccccccccccccccc.
- R2: With `count_from_lsb` = 1, the count runs from the least significant selected position upward under the same stopping rule. Data 0xfedcba9876543210 gives 4 with mask 0xaaaaaaaaaaaaaaaa and 8 with mask 0xcccccccccccccccc.
- R3: Data bits at positions whose mask bit is 0 have no effect on the count. A 1 in such a position does not stop the run, and a 0 in such a position is not counted.
- R4: When no selected data bit is 1, the count equals the number of 1 bits in the lane's mask. An all-zero mask gives 0.
- R5: Lane 0 uses bits 63:0 and lane 1 uses bits 127:64 of every operand and of the result. The two lanes are counted independently of each other.
- R6: Each count is returned in bits 6:0 of its 64-bit result lane, and bits 63:7 of that lane are 0.
- R7: `out_valid` equals the value `in_valid` had one clock earlier. When `in_valid` is 1, the matching result is on `result_o` after that same edge.
- R8: While `in_valid` is 0, `result_o` keeps its previous value, whatever happens on the other inputs.
- R9: While reset is asserted, and until the synchronised release has taken effect, `out_valid` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset. Release is synchronised inside the block. |
| in_valid | input | 1 | Operands are valid this cycle |
| count_from_lsb | input | 1 | 0 counts from the most significant end, 1 counts from the least significant end |
| data_i | input | 128 | Data operand, two 64-bit lanes |
| mask_i | input | 128 | Selection mask, two 64-bit lanes |
| out_valid | output | 1 | Result is valid |
| result_o | output | 128 | Zero-extended count for each lane |

## Verification
The bench applies masks with no bits set, with every bit set, and with a single bit set. A design that tests the data bit without first applying the mask would stop early on an unselected 1, or would count unselected zeros. Such a design gives wrong counts on sparse masks, and it gives 64 instead of 0 on an empty mask.

Data that is zero at every selected position checks the case where the run never stops. Here a count register one bit too narrow would wrap to 0 at 64.

The two lanes get different patterns and different masks, which exposes lane indices that are crossed or shared. Idle cycles carrying changed operands show whether a result register is missing its clock enable.

// File: rtl/mzc_pkg.sv
package mzc_pkg;
  localparam int unsigned LANE_W = 64;
  localparam int unsigned LANES  = 2;
  localparam int unsigned CNT_W  = $clog2(LANE_W + 1);
  localparam int unsigned BUS_W  = LANE_W * LANES;
endpackage

// File: rtl/mzc_rst_sync.sv
module mzc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mzc_orient.sv
// Optionally mirrors a lane so the counter always scans from its top bit.
module mzc_orient #(
  parameter int unsigned W = 64
) (
  input  logic         flip,
  input  logic [W-1:0] in_bits,
  output logic [W-1:0] out_bits
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out_bits[i] = flip ? in_bits[W-1-i] : in_bits[i];
  end
endmodule

// File: rtl/mzc_lane_count.sv
// Counts selected zeros from the top of the (already oriented) lane.
module mzc_lane_count #(
  parameter int unsigned W     = 64,
  parameter int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     data_bits,
  input  logic [W-1:0]     sel_bits,
  output logic [CNT_W-1:0] run_len
);
  logic [W-1:0] hit;
  logic [W:0]   blocked;   // blocked[i] : a selected one lies at or above i

  assign hit = data_bits & sel_bits;

  always_comb begin
    blocked[W] = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      blocked[i] = blocked[i+1] | hit[i];
    end
  end

  always_comb begin
    run_len = '0;
    for (int i = 0; i < W; i++) begin
      if (sel_bits[i] && !blocked[i]) run_len = run_len + 1'b1;
    end
  end
endmodule

// File: rtl/mzc_top.sv
module mzc_top
  import mzc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             count_from_lsb,
  input  logic [BUS_W-1:0] data_i,
  input  logic [BUS_W-1:0] mask_i,
  output logic             out_valid,
  output logic [BUS_W-1:0] result_o
);
  localparam int unsigned PAD_W = LANE_W - CNT_W;

  logic             rst_sync_n;
  logic [BUS_W-1:0] res_comb;
  logic [BUS_W-1:0] res_d;
  logic [BUS_W-1:0] res_q;
  logic             vld_d;
  logic             vld_q;

  mzc_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] d_or;
    logic [LANE_W-1:0] m_or;
    logic [CNT_W-1:0]  cnt;
    logic [LANE_W-1:0] lane_res;

    mzc_orient #(.W(LANE_W)) i_orient_d (
      .flip     (count_from_lsb),
      .in_bits  (data_i[l*LANE_W +: LANE_W]),
      .out_bits (d_or)
    );

    mzc_orient #(.W(LANE_W)) i_orient_m (
      .flip     (count_from_lsb),
      .in_bits  (mask_i[l*LANE_W +: LANE_W]),
      .out_bits (m_or)
    );

    mzc_lane_count #(.W(LANE_W), .CNT_W(CNT_W)) i_count (
      .data_bits (d_or),
      .sel_bits  (m_or),
      .run_len   (cnt)
    );

    assign res_comb[l*LANE_W +: LANE_W] = {{PAD_W{1'b0}}, cnt};
    assign lane_res = res_q[l*LANE_W +: LANE_W];

    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      lane_res[LANE_W-1:CNT_W] == '0);

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      in_valid |=> lane_res <= LANE_W'($countones($past(mask_i[l*LANE_W +: LANE_W]))));

    // R4
    empty_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (in_valid && mask_i[l*LANE_W +: LANE_W] == '0) |=> lane_res == '0);
  end

  always_comb begin
    vld_d = in_valid;
    res_d = in_valid ? res_comb : res_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      res_q <= res_d;
    end
  end

  assign out_valid = vld_q;
  assign result_o  = res_q;

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> $stable(result_o));
endmodule

// File: tb/test_mzc_top.sv
module test_mzc_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         count_from_lsb;
  logic [127:0] data_i;
  logic [127:0] mask_i;
  logic         out_valid;
  logic [127:0] result_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mzc_top i_mzc_top (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .count_from_lsb (count_from_lsb),
    .data_i         (data_i),
    .mask_i         (mask_i),
    .out_valid      (out_valid),
    .result_o       (result_o)
  );

  function automatic logic [63:0] ref_count(logic [63:0] d, logic [63:0] m, logic from_lsb);
    logic [63:0] n = 0;
    for (int k = 0; k < 64; k++) begin
      int p = from_lsb ? k : 63 - k;
      if (m[p]) begin
        if (d[p]) return n;
        n++;
      end
    end
    return n;
  endfunction

  task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // applies one operand set and checks the registered result one clock later
  task automatic apply(string tag, logic [127:0] d, logic [127:0] m, logic dir);
    logic [127:0] exp;
    @(negedge clk);
    in_valid = 1'b1; data_i = d; mask_i = m; count_from_lsb = dir;
    exp = {ref_count(d[127:64], m[127:64], dir), ref_count(d[63:0], m[63:0], dir)};
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R7 valid"}, {127'd0, out_valid}, 128'd1);
    check(tag, result_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [127:0] held;
    void'($urandom(32'd7321));
    rst_n = 1'b0; in_valid = 1'b0; count_from_lsb = 1'b0;
    data_i = '1; mask_i = '1;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {127'd0, out_valid}, 128'd0);
    check("R9 reset result", result_o, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 sync release valid", {127'd0, out_valid}, 128'd0);
    repeat (3) @(negedge clk);

    // examples from the requirements
    apply("R1 leading example",
          {64'h0123456789abcdef, 64'h0123456789abcdef},
          {64'hcccccccccccccccc, 64'haaaaaaaaaaaaaaaa}, 1'b0);
    check("R1 leading lane values", result_o, {64'd9, 64'd5});
    apply("R2 trailing example",
          {64'hfedcba9876543210, 64'hfedcba9876543210},
          {64'hcccccccccccccccc, 64'haaaaaaaaaaaaaaaa}, 1'b1);
    check("R2 trailing lane values", result_o, {64'd8, 64'd4});

    // R3: ones only outside the mask are skipped
    apply("R3 unselected ones", {64'h5555555555555555, 64'h5555555555555555},
          {64'haaaaaaaaaaaaaaaa, 64'haaaaaaaaaaaaaaaa}, 1'b0);
    check("R3 unselected ones value", result_o, {64'd32, 64'd32});
    apply("R3 unselected trailing", {64'h00000000000000ff, 64'h0f},
          {64'hffffffffffffff00, 64'hf0}, 1'b1);

    // R4: no selected one, empty mask, full mask
    apply("R4 all zero full mask lead", 128'd0, '1, 1'b0);
    check("R4 count 64", result_o, {64'd64, 64'd64});
    apply("R4 all zero full mask trail", 128'd0, '1, 1'b1);
    apply("R4 empty mask", '1, 128'd0, 1'b0);
    check("R4 empty mask zero", result_o, 128'd0);
    apply("R4 ones everywhere", '1, '1, 1'b1);

    // R5: distinct lanes
    apply("R5 lane independence", {64'h8000000000000000, 64'd0},
          {64'hffffffffffffffff, 64'h8000000000000001}, 1'b0);
    check("R5 lane values", result_o, {64'd0, 64'd2});

    // R8: idle cycle with changed operands
    held = result_o;
    @(negedge clk);
    data_i = '1; mask_i = 128'h1; count_from_lsb = 1'b1;
    @(negedge clk);
    check("R7 idle valid", {127'd0, out_valid}, 128'd0);
    check("R8 hold", result_o, held);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [127:0] d, m;
      d = {$urandom, $urandom, $urandom, $urandom};
      m = {$urandom, $urandom, $urandom, $urandom};
      case (n % 4)
        1: d = d & {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
        2: m = m & {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom};
        3: d = d & {$urandom, $urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom, $urandom}
                 & {$urandom, $urandom, $urandom, $urandom};
        default: ;
      endcase
      apply(((n % 2) != 0) ? "R2 R3 R6 random trailing" : "R1 R3 R6 random leading", d, m, 1'(n % 2));
    end

    // R9: asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 reset clears result", result_o, 128'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    report();
  end
endmodule